// File: doc/BRIEF.md
# Dual-Mode Processor Timer

This block holds a bank of timers: one system timer at index 0 and one timer for each processor at indices 1 and up. A timer in counter mode counts a shared tick input up to a programmable terminal value. There it wraps to zero and latches a limit-reached flag that drives its interrupt line. Software writes one bit per timer into a shared mode register to turn a processor timer into a wide free-running profiling counter. In that mode a stored run bit starts and stops the count, and no interrupt is raised.

Software reaches the block through a 32-bit register port with single-cycle write and read strobes. Read data is registered and appears on the cycle after the read strobe. The word address is `{timer index, register select}`, with a 3-bit select:

| Select | Meaning |
|--------|---------|
| 0 | limit |
| 1 | count high |
| 2 | count low |
| 3 | run |
| 4 | shared mode |

The run bit is always stored. It only gates counting in profiling mode, so a value written while in counter mode takes effect at the next entry into profiling mode.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset, every timer is in counter mode and counting. The limit reads 0x003FFFFF (flag bit 31 clear), a processor timer's run bit reads 1, the mode register reads 0, and all interrupt lines are low.
- R2: In counter mode each tick increments the count. A tick that finds the count equal to limit-1 wraps the count to 0, sets the limit-reached flag, and raises that timer's interrupt in the next cycle.
- R3: A read of the limit register returns the flag in bit 31 and the limit in bits 21:0. The read then clears the flag and the interrupt; a limit hit in the same cycle takes precedence over the clear.
- R4: A write to the limit register in counter mode loads bits 21:0 and clears the count to 0.
- R5: A write to the run register always stores bit 0, and a read returns the stored bit. In counter mode the stored value does not stop counting.
- R6: In profiling mode the 54-bit count increments on each tick only while the run bit is 1, and the interrupt stays low.
- R7: Setting a timer's mode bit clears its interrupt and flag, clears its count, and forces its limit to 0x3FFFFF. Counting then continues only if the stored run bit is 1.
- R8: Clearing a timer's mode bit clears its count and restarts counting whatever the run bit holds.
- R9: In profiling mode a read of count high returns count bits 53:32 and latches bits 31:0. Count low returns that latched word, not the live count. In counter mode count low returns the live count and count high returns 0.
- R10: For the system timer, mode bit 0 is ignored and always reads 0, so it stays a counter that can interrupt. Its run register reads 0.
- R11: Select values 5 to 7, and timer indices with no timer, read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable pulse shared by all timers |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Single-cycle read strobe |
| addr | input | ADDR_W | Word address `{index, select}` |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid the cycle after rdEn |
| irq | output | NUM_TMR | Per-timer interrupt, high while the limit-reached flag is set |

## Verification
A count register that is wrongly cleared, or that misses an enable, shows at the count-low port on the next read, one cycle after the read strobe. A wrong terminal compare shows as an interrupt one tick early or late; the bench samples the interrupt just before and just after the boundary tick. Mode-switch faults leave marks that persist and can be read: a run bit ignored on entry to profiling mode leaves a nonzero count, a missing restart on return leaves a zero count, and a missing limit force is seen later as a stale limit value. A latched low word that follows the live count is caught by ticking between the high and low reads.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

  // Per-timer strobes from register decode to one datapath instance
  typedef struct packed {
    logic wrLimit;    // load limit, clear count (counter mode only)
    logic rdLimit;    // limit read: clear reached flag
    logic rdHigh;     // high-word read in profiling mode: latch low word
    logic toUser;     // mode bit 0 -> 1
    logic toCounter;  // mode bit 1 -> 0
  } tmrStrobe_t;

endpackage

// File: rtl/dmt_datapath.sv
module dmt_datapath
  import dmt_pkg::*;
#(
  parameter int CNT_W = 22,
  parameter int USR_W = 54
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             userMode,
  input  logic             cntEn,
  input  tmrStrobe_t       strb,
  input  logic [CNT_W-1:0] limData,
  output logic [USR_W-1:0] count,
  output logic [CNT_W-1:0] limit,
  output logic             reached,
  output logic [31:0]      shadow
);

  logic [CNT_W-1:0] termVal;
  logic             hitLimit;

  // limit 0 gives terminal all-ones, i.e. the full 2^CNT_W range
  assign termVal  = limit - CNT_W'(1);
  assign hitLimit = tick && cntEn && !userMode && (count[CNT_W-1:0] == termVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      limit <= '1;
    end else if (strb.toUser) begin
      count <= '0;
      limit <= '1;
    end else if (strb.toCounter) begin
      count <= '0;
    end else if (strb.wrLimit && !userMode) begin
      count <= '0;
      limit <= limData;
    end else if (hitLimit) begin
      count <= '0;
    end else if (tick && cntEn) begin
      count <= count + USR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              reached <= 1'b0;
    else if (strb.toUser)   reached <= 1'b0;
    else if (hitLimit)      reached <= 1'b1;
    else if (strb.rdLimit)  reached <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            shadow <= '0;
    else if (strb.rdHigh) shadow <= count[31:0];
  end

endmodule

// File: rtl/dmt_ctrl.sv
module dmt_ctrl
  import dmt_pkg::*;
#(
  parameter int NUM_TMR = 3,
  parameter int CNT_W   = 22,
  parameter int USR_W   = 54,
  parameter int ADDR_W  = 5
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            wrEn,
  input  logic                            rdEn,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [31:0]                     wdata,
  input  logic [NUM_TMR-1:0][USR_W-1:0]   cntVal,
  input  logic [NUM_TMR-1:0][CNT_W-1:0]   limVal,
  input  logic [NUM_TMR-1:0]              reachedVal,
  input  logic [NUM_TMR-1:0][31:0]        shadowVal,
  output tmrStrobe_t [NUM_TMR-1:0]        strb,
  output logic [NUM_TMR-1:0]              userMode,
  output logic [NUM_TMR-1:0]              cntEn,
  output logic [CNT_W-1:0]                limData,
  output logic [31:0]                     rdata
);

  localparam int SEL_W = 3;
  localparam int IDX_W = ADDR_W - SEL_W;
  localparam int HI_W  = USR_W - 32;
  localparam logic [SEL_W-1:0] SEL_LIMIT = 3'd0;
  localparam logic [SEL_W-1:0] SEL_HIGH  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_LOW   = 3'd2;
  localparam logic [SEL_W-1:0] SEL_RUN   = 3'd3;
  localparam logic [SEL_W-1:0] SEL_MODE  = 3'd4;

  logic [IDX_W-1:0]   idx;
  logic [SEL_W-1:0]   sel;
  logic               idxOk;
  logic               modeWr;
  logic [NUM_TMR-1:0] modeReg, runReg, modeNext;
  logic [31:0]        rdNext;
  logic               unusedBits;

  assign idx      = addr[ADDR_W-1:SEL_W];
  assign sel      = addr[SEL_W-1:0];
  assign idxOk    = int'(idx) < NUM_TMR;
  assign modeWr   = wrEn && idxOk && (sel == SEL_MODE);
  // system timer bit is held at zero
  assign modeNext = wdata[NUM_TMR-1:0] & ~NUM_TMR'(1);
  assign limData  = wdata[CNT_W-1:0];
  assign userMode = modeReg;
  assign cntEn    = ~modeReg | runReg;

  always_comb begin
    unusedBits = ^wdata[31:CNT_W];
    for (int i = 0; i < NUM_TMR; i++) unusedBits ^= ^cntVal[i][31:CNT_W];
  end

  always_comb begin
    for (int i = 0; i < NUM_TMR; i++) begin
      strb[i].wrLimit   = wrEn && (idx == IDX_W'(i)) && (sel == SEL_LIMIT);
      strb[i].rdLimit   = rdEn && (idx == IDX_W'(i)) && (sel == SEL_LIMIT);
      strb[i].rdHigh    = rdEn && (idx == IDX_W'(i)) && (sel == SEL_HIGH) && modeReg[i];
      strb[i].toUser    = modeWr && modeNext[i] && !modeReg[i];
      strb[i].toCounter = modeWr && !modeNext[i] && modeReg[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      runReg  <= '1;
    end else begin
      if (modeWr) modeReg <= modeNext;
      for (int i = 1; i < NUM_TMR; i++)
        if (wrEn && (sel == SEL_RUN) && (idx == IDX_W'(i))) runReg[i] <= wdata[0];
    end
  end

  always_comb begin
    rdNext = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (idx == IDX_W'(i)) begin
        case (sel)
          SEL_LIMIT: rdNext = {reachedVal[i], {(31-CNT_W){1'b0}}, limVal[i]};
          SEL_HIGH:  rdNext = modeReg[i] ? {{(32-HI_W){1'b0}}, cntVal[i][USR_W-1:32]} : 32'd0;
          SEL_LOW:   rdNext = modeReg[i] ? shadowVal[i]
                                         : {{(32-CNT_W){1'b0}}, cntVal[i][CNT_W-1:0]};
          SEL_RUN:   rdNext = (i == 0) ? 32'd0 : {31'd0, runReg[i]};
          SEL_MODE:  rdNext = {{(32-NUM_TMR){1'b0}}, modeReg};
          default:   rdNext = 32'd0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdata <= '0;
    else if (rdEn) rdata <= rdNext;
  end

endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
  import dmt_pkg::*;
#(
  parameter  int NUM_TMR = 3,
  parameter  int CNT_W   = 22,
  parameter  int USR_W   = 54,
  localparam int ADDR_W  = $clog2(NUM_TMR) + 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tick,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  output logic [NUM_TMR-1:0] irq
);

  tmrStrobe_t [NUM_TMR-1:0]            strbW;
  logic [NUM_TMR-1:0]                  userModeW, cntEnW, reachedW;
  logic [NUM_TMR-1:0][USR_W-1:0]       cntW;
  logic [NUM_TMR-1:0][CNT_W-1:0]       limW;
  logic [NUM_TMR-1:0][31:0]            shadowW;
  logic [CNT_W-1:0]                    limDataW;

  dmt_ctrl #(
    .NUM_TMR(NUM_TMR), .CNT_W(CNT_W), .USR_W(USR_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wdata(wdata),
    .cntVal(cntW), .limVal(limW), .reachedVal(reachedW), .shadowVal(shadowW),
    .strb(strbW), .userMode(userModeW), .cntEn(cntEnW), .limData(limDataW),
    .rdata(rdata)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    dmt_datapath #(.CNT_W(CNT_W), .USR_W(USR_W)) u_dp (
      .clk(clk), .rstN(rstN), .tick(tick), .userMode(userModeW[i]), .cntEn(cntEnW[i]),
      .strb(strbW[i]), .limData(limDataW), .count(cntW[i]), .limit(limW[i]),
      .reached(reachedW[i]), .shadow(shadowW[i])
    );
  end

  assign irq = reachedW;

endmodule

// File: rtl/dmt_checker.sv
module dmt_checker #(
  parameter int NUM_TMR = 3,
  parameter int ADDR_W  = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               tick,
  input logic               rdEn,
  input logic [ADDR_W-1:0]  addr,
  input logic [NUM_TMR-1:0] irq,
  input logic [NUM_TMR-1:0] userMode,
  input logic [31:0]        rdata
);

  localparam int IDX_W = ADDR_W - 3;

  a_r10_sys_counter: assert property (@(posedge clk) disable iff (!rstN) !userMode[0]);

  a_r11_unmapped_sel: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr[2:0] > 3'd4) |=> (rdata == 32'd0));

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
    a_r6_no_irq_user: assert property (@(posedge clk) disable iff (!rstN)
      userMode[i] |-> !irq[i]);

    a_r2_irq_after_tick: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irq[i]) |-> $past(tick));

    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rstN)
      (rdEn && !tick && addr == {IDX_W'(i), 3'd0}) |=> !irq[i]);
  end

endmodule

bind dual_mode_timer dmt_checker #(.NUM_TMR(NUM_TMR), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .rdEn(rdEn), .addr(addr),
  .irq(irq), .userMode(userModeW), .rdata(rdata)
);

// File: tb/dual_mode_timer_bench.sv
`timescale 1ns/1ps
module dual_mode_timer_bench;

  localparam int NT = 3;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tick = 1'b0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NT-1:0] irq;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  // addresses: {index, select}; select 0 limit,1 high,2 low,3 run,4 mode
  localparam logic [AW-1:0] T0_LIM = 5'd0,  T0_RUN = 5'd3;
  localparam logic [AW-1:0] T1_LIM = 5'd8,  T1_HI = 5'd9, T1_LO = 5'd10;
  localparam logic [AW-1:0] T1_RUN = 5'd11, MODE = 5'd12;

  always #2 clk = ~clk;

  dual_mode_timer u_dual_mode_timer (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdata;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", 32'(irq), 32'd0);
    rd(T1_LIM, d); chk("R1 limit", d, 32'h003F_FFFF);
    rd(T1_RUN, d); chk("R1 run", d, 32'd1);
    rd(MODE, d);   chk("R1 mode", d, 32'd0);
    rd(T0_RUN, d); chk("R10 sys run", d, 32'd0);
  endtask

  task automatic t_counter;
    logic [31:0] d;
    ticks(2);
    wr(T1_LIM, 32'd5);
    rd(T1_LO, d); chk("R4 count cleared", d, 32'd0);
    ticks(3);
    rd(T1_LO, d); chk("R2 count", d, 32'd3);
    ticks(1);
    chk("R2 no irq before limit", 32'(irq[1]), 32'd0);
    ticks(1);
    chk("R2 irq at limit", 32'(irq[1]), 32'd1);
    rd(T1_LO, d); chk("R2 wrap", d, 32'd0);
    rd(T1_LIM, d); chk("R3 flag read", d, 32'h8000_0005);
    chk("R3 irq cleared", 32'(irq[1]), 32'd0);
    rd(T1_LIM, d); chk("R3 flag cleared", d, 32'h0000_0005);
  endtask

  task automatic t_run_counter;
    logic [31:0] d;
    wr(T1_RUN, 32'd0);
    rd(T1_RUN, d); chk("R5 run stored", d, 32'd0);
    wr(T1_LIM, 32'd100);
    ticks(2);
    rd(T1_LO, d); chk("R5 counter ignores run", d, 32'd2);
  endtask

  task automatic t_to_user;
    logic [31:0] d;
    wr(T1_LIM, 32'd2);
    ticks(2);
    chk("R2 irq limit 2", 32'(irq[1]), 32'd1);
    wr(MODE, 32'd2);
    chk("R7 irq cleared", 32'(irq[1]), 32'd0);
    ticks(3);
    rd(T1_HI, d); chk("R7 high stopped", d, 32'd0);
    rd(T1_LO, d); chk("R7 stopped with run 0", d, 32'd0);
  endtask

  task automatic t_user_run;
    logic [31:0] d;
    wr(T1_RUN, 32'd1);
    ticks(5);
    chk("R6 no irq", 32'(irq[1]), 32'd0);
    rd(T1_HI, d); chk("R9 high", d, 32'd0);
    rd(T1_LO, d); chk("R6 counting", d, 32'd5);
    ticks(2);
    rd(T1_LO, d); chk("R9 low latched", d, 32'd5);
    rd(T1_HI, d);
    rd(T1_LO, d); chk("R9 relatch", d, 32'd7);
  endtask

  task automatic t_back;
    logic [31:0] d;
    wr(T1_RUN, 32'd0);
    wr(MODE, 32'd0);
    ticks(4);
    rd(T1_LO, d);  chk("R8 counts with run 0", d, 32'd4);
    rd(MODE, d);   chk("R8 mode cleared", d, 32'd0);
    rd(T1_LIM, d); chk("R7 limit forced max", d, 32'h003F_FFFF);
  endtask

  task automatic t_sys;
    logic [31:0] d;
    wr(MODE, 32'd3);
    rd(MODE, d); chk("R10 bit0 ignored", d, 32'd2);
    wr(T0_LIM, 32'd3);
    ticks(3);
    chk("R10 sys irq", 32'(irq[0]), 32'd1);
    wr(T0_RUN, 32'd1);
    rd(T0_RUN, d); chk("R10 sys run reads 0", d, 32'd0);
    rd(T0_LIM, d); chk("R10 sys flag", d, 32'h8000_0003);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(MODE, d);   chk("R11 setup", d, 32'd2);
    rd(5'd13, d);  chk("R11 select 5", d, 32'd0);
    rd(5'd28, d);  chk("R11 index 3", d, 32'd0);
    rd(MODE, d);
    rd(5'd7, d);   chk("R11 select 7", d, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_counter();
    t_run_counter();
    t_to_user();
    t_user_run();
    t_back();
    t_sys();
    t_unmapped();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule